// File: doc/BRIEF.md
# General-Purpose I/O Bank Controller

This block controls one bank of general-purpose pins through a small register bus with a byte address, a write strobe, write data and read data. For each pin it keeps an output latch, a direction bit, a pull-disable bit and two alternate-select bits. Software can load any of these registers whole. For the output latch and the direction register it can also write a mask to a set alias or a clear alias, so a single pin changes without a read-modify-write sequence.

The bank drives output-value, output-enable, pull-disable and alternate-select vectors toward the pads. It brings the pad levels back through a two-stage synchronizer. Reading the data word returns those synchronized levels. Reading a set or clear alias returns the register behind it. The raw reset input is asserted asynchronously and released through a two-flop stage, so every register leaves reset on a clock edge. Read data is combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a plain GPIO input with its pull enabled. pin_out, pin_oe, pin_pull_dis, pin_alt_a and pin_alt_b are all zero, and every register readback other than the data word returns zero.
- R2: A write to byte offset 0x04 (data-set) sets every output-latch bit whose write-data bit is 1 and leaves the other bits unchanged. pin_out shows the new value from the clock edge that takes the write.
- R3: A write to offset 0x08 (data-clear) clears every output-latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x00 loads the whole output latch, and pin_out follows it.
- R5: Writes to offset 0x14 (direction-set) and offset 0x18 (direction-clear) set or clear the masked direction bits. pin_oe equals the direction register, where 1 means output and 0 means input.
- R6: A write to offset 0x10 loads the whole direction register.
- R7: A read of offset 0x00 returns the pin_in levels, one bit per pin. A change on pin_in is invisible after the first rising edge and visible after the second.
- R8: Offset 0x0C holds the pull-disable register, where 1 turns the pull off. It drives pin_pull_dis and reads back as written.
- R9: Offset 0x20 holds the A-select bits and offset 0x24 holds the B-select bits. Both drive pin_alt_a and pin_alt_b and read back as written. For each pin the mode code {B,A} means 00 plain GPIO, 01 alternate A, 10 alternate B and 11 alternate C.
- R10: Bits at or above NPINS read as zero and are ignored on write. An address that is not listed above, or whose low two bits are not zero, reads as zero, and a write to it changes no register.
- R11: Reading offsets 0x04 and 0x08 returns the output latch. Reading offsets 0x14 and 0x18 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| pin_pull_dis | output | NPINS | Pull disable per pin, 1 = pull off |
| pin_alt_a | output | NPINS | A-select bit of the pin mode |
| pin_alt_b | output | NPINS | B-select bit of the pin mode |

## Verification
The bench sweeps every set and clear mask against varied starting latch values. A design that let zero bits act, or that confused the data and direction aliases, would leave a wrong pin_out or pin_oe after one of those writes. It times the input path edge by edge, which exposes a synchronizer that is one stage too short or too long. It also writes all ones to unmapped and misaligned addresses and to the bits above the pin count. A loose decoder would then change a register or return nonzero read data. Every pin is walked through all four mode codes, which catches swapped A and B selects.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  // bus data width
  localparam int DW = 32;
  // word indices (byte offset / 4)
  localparam int unsigned W_LEVEL   = 0;
  localparam int unsigned W_OUT_SET = 1;
  localparam int unsigned W_OUT_CLR = 2;
  localparam int unsigned W_PULLOFF = 3;
  localparam int unsigned W_DIR     = 4;
  localparam int unsigned W_DIR_SET = 5;
  localparam int unsigned W_DIR_CLR = 6;
  localparam int unsigned W_SEL_A   = 8;
  localparam int unsigned W_SEL_B   = 9;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] meta_d;
  logic [WIDTH-1:0] stab_d;

  always_comb begin
    meta_d = din;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= meta_d;
      dout   <= stab_d;
    end
  end

  // edges seen since reset, saturating; used only by the check below
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R7: two-edge latency from pad to readable level
  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_bank_screg.sv
`timescale 1ns/1ps
module gpio_bank_screg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_val,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en = wr_en | (|set_i) | (|clr_i);
    if (wr_en) q_d = wr_val;
    else       q_d = (q_o | set_i) & ~clr_i;   // clear wins on overlap
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_d;
  end

  // R2: masked set bits land, clear-free bits only
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && |(set_i & ~clr_i)) |=>
      ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  // R3: masked clear bits end low
  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && |clr_i) |=> ((q_o & $past(clr_i)) == '0));
  // R10: no strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/gpio_bank_wdec.sv
`timescale 1ns/1ps
module gpio_bank_wdec
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IW    = 6
) (
  input  logic [IW-1:0]    idx,
  input  logic             aligned,
  input  logic             we,
  input  logic [NPINS-1:0] wval,
  output logic             out_wr,
  output logic             dir_wr,
  output logic [2:0]       plain_wr,   // 0 pull-off, 1 sel A, 2 sel B
  output logic [NPINS-1:0] out_set,
  output logic [NPINS-1:0] out_clr,
  output logic [NPINS-1:0] dir_set,
  output logic [NPINS-1:0] dir_clr
);
  always_comb begin
    out_wr   = 1'b0;
    dir_wr   = 1'b0;
    plain_wr = 3'b000;
    out_set  = '0;
    out_clr  = '0;
    dir_set  = '0;
    dir_clr  = '0;
    if (we && aligned) begin
      case (idx)
        IW'(W_LEVEL):   out_wr      = 1'b1;
        IW'(W_OUT_SET): out_set     = wval;
        IW'(W_OUT_CLR): out_clr     = wval;
        IW'(W_PULLOFF): plain_wr[0] = 1'b1;
        IW'(W_DIR):     dir_wr      = 1'b1;
        IW'(W_DIR_SET): dir_set     = wval;
        IW'(W_DIR_CLR): dir_clr     = wval;
        IW'(W_SEL_A):   plain_wr[1] = 1'b1;
        IW'(W_SEL_B):   plain_wr[2] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
`timescale 1ns/1ps
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IW    = 6
) (
  input  logic [IW-1:0]    idx,
  input  logic             aligned,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] pull_q,
  input  logic [NPINS-1:0] sela_q,
  input  logic [NPINS-1:0] selb_q,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (idx)
        IW'(W_LEVEL):   rdata = DW'(lvl);
        IW'(W_OUT_SET),
        IW'(W_OUT_CLR): rdata = DW'(out_q);
        IW'(W_PULLOFF): rdata = DW'(pull_q);
        IW'(W_DIR),
        IW'(W_DIR_SET),
        IW'(W_DIR_CLR): rdata = DW'(dir_q);
        IW'(W_SEL_A):   rdata = DW'(sela_q);
        IW'(W_SEL_B):   rdata = DW'(selb_q);
        default:        rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_pull_dis,
  output logic [NPINS-1:0] pin_alt_a,
  output logic [NPINS-1:0] pin_alt_b
);
  localparam int IW = AW - 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [IW-1:0] idx;
  logic          aligned;
  assign idx     = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic             out_wr, dir_wr;
  logic [2:0]       plain_wr;
  logic [NPINS-1:0] out_set, out_clr, dir_set, dir_clr;
  logic [NPINS-1:0] wval;
  assign wval = bus_wdata[NPINS-1:0];

  gpio_bank_wdec #(.NPINS(NPINS), .IW(IW)) u_wdec (
    .idx(idx), .aligned(aligned), .we(bus_we), .wval(wval),
    .out_wr(out_wr), .dir_wr(dir_wr), .plain_wr(plain_wr),
    .out_set(out_set), .out_clr(out_clr),
    .dir_set(dir_set), .dir_clr(dir_clr)
  );

  logic [NPINS-1:0] out_q, dir_q;

  gpio_bank_screg #(.WIDTH(NPINS)) u_out (
    .clk(clk), .rst_n(rst_core_n), .wr_en(out_wr), .wr_val(wval),
    .set_i(out_set), .clr_i(out_clr), .q_o(out_q)
  );

  gpio_bank_screg #(.WIDTH(NPINS)) u_dir (
    .clk(clk), .rst_n(rst_core_n), .wr_en(dir_wr), .wr_val(wval),
    .set_i(dir_set), .clr_i(dir_clr), .q_o(dir_q)
  );

  // whole-word registers: pull-off, select A, select B
  logic [NPINS-1:0] plain_q [3];
  for (genvar g = 0; g < 3; g++) begin : g_plain
    gpio_bank_screg #(.WIDTH(NPINS)) u_plain (
      .clk(clk), .rst_n(rst_core_n), .wr_en(plain_wr[g]), .wr_val(wval),
      .set_i('0), .clr_i('0), .q_o(plain_q[g])
    );
  end

  logic [NPINS-1:0] lvl;
  gpio_bank_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .din(pin_in), .dout(lvl)
  );

  gpio_bank_rdmux #(.NPINS(NPINS), .IW(IW)) u_rdmux (
    .idx(idx), .aligned(aligned), .lvl(lvl),
    .out_q(out_q), .dir_q(dir_q), .pull_q(plain_q[0]),
    .sela_q(plain_q[1]), .selb_q(plain_q[2]), .rdata(bus_rdata)
  );

  assign pin_out      = out_q;
  assign pin_oe       = dir_q;
  assign pin_pull_dis = plain_q[0];
  assign pin_alt_a    = plain_q[1];
  assign pin_alt_b    = plain_q[2];

  // R5: a direction-set write without clear turns those pins into drivers
  p_dirset_oe_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && aligned && idx == IW'(W_DIR_SET)) |=>
      ((pin_oe & $past(wval)) == $past(wval)));
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NP = 8;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, pin_pull_dis, pin_alt_a, pin_alt_b;

  gpio_bank #(.NPINS(NP), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_dis(pin_pull_dis),
    .pin_alt_a(pin_alt_a), .pin_alt_b(pin_alt_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int errs   = 0;
  int checks = 0;

  // reference model
  logic [NP-1:0] m_out, m_dir, m_pull, m_a, m_b, m_lvl;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    chk({tag, " R4 pin_out"}, 32'(pin_out), 32'(m_out));
    chk({tag, " R5 pin_oe"},  32'(pin_oe),  32'(m_dir));
    chk({tag, " R8 pin_pull_dis"}, 32'(pin_pull_dis), 32'(m_pull));
    chk({tag, " R9 pin_alt_a"}, 32'(pin_alt_a), 32'(m_a));
    chk({tag, " R9 pin_alt_b"}, 32'(pin_alt_b), 32'(m_b));
    rd(8'h04, r); chk({tag, " R11 rd 04"}, r, 32'(m_out));
    rd(8'h08, r); chk({tag, " R11 rd 08"}, r, 32'(m_out));
    rd(8'h0C, r); chk({tag, " R8 rd 0C"},  r, 32'(m_pull));
    rd(8'h10, r); chk({tag, " R6 rd 10"},  r, 32'(m_dir));
    rd(8'h14, r); chk({tag, " R11 rd 14"}, r, 32'(m_dir));
    rd(8'h18, r); chk({tag, " R11 rd 18"}, r, 32'(m_dir));
    rd(8'h20, r); chk({tag, " R9 rd 20"},  r, 32'(m_a));
    rd(8'h24, r); chk({tag, " R9 rd 24"},  r, 32'(m_b));
    rd(8'h00, r); chk({tag, " R7 rd 00"},  r, 32'(m_lvl));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [NP-1:0] base, exp_v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    m_out = '0; m_dir = '0; m_pull = '0; m_a = '0; m_b = '0; m_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // R4: full-word loads, upper bits ignored (R10)
    for (int v = 0; v < 256; v++) begin
      wr(8'h00, {24'hA5C3E1, 8'(v)});
      m_out = NP'(v);
      chk("R4 pin_out after load", 32'(pin_out), 32'(m_out));
      rd(8'h04, r); chk("R10 R11 latch readback upper zero", r, 32'(m_out));
    end

    // R2/R3: set and clear masks over varied starting values
    for (int v = 0; v < 256; v++) begin
      base = NP'(v * 73 + 5);
      wr(8'h00, 32'(base));
      wr(8'h04, 32'(v));
      exp_v = base | NP'(v);
      chk("R2 data-set", 32'(pin_out), 32'(exp_v));
      wr(8'h08, 32'(NP'(v * 29 + 3)));
      exp_v = exp_v & ~NP'(v * 29 + 3);
      chk("R3 data-clear", 32'(pin_out), 32'(exp_v));
    end
    m_out = exp_v;

    // R5/R6: direction load, set, clear
    for (int v = 0; v < 256; v++) begin
      base = NP'(v * 41 + 11);
      wr(8'h10, 32'(base));
      chk("R6 dir load", 32'(pin_oe), 32'(base));
      wr(8'h14, 32'(v));
      exp_v = base | NP'(v);
      chk("R5 dir-set", 32'(pin_oe), 32'(exp_v));
      wr(8'h18, 32'(NP'(v * 13 + 7)));
      exp_v = exp_v & ~NP'(v * 13 + 7);
      chk("R5 dir-clear", 32'(pin_oe), 32'(exp_v));
      chk("R5 dir ops leave latch", 32'(pin_out), 32'(m_out));
    end
    m_dir = exp_v;

    // R8: pull-disable
    for (int v = 0; v < 256; v++) begin
      wr(8'h0C, 32'hFFFF_FF00 | 32'(v));
      m_pull = NP'(v);
      chk("R8 pin_pull_dis", 32'(pin_pull_dis), 32'(m_pull));
      rd(8'h0C, r); chk("R8 R10 pull readback", r, 32'(m_pull));
    end

    // R9: every pin through every mode code
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 4; c++) begin
        m_a = NP'((c & 1) << p);
        m_b = NP'(((c >> 1) & 1) << p);
        wr(8'h20, 32'(m_a));
        wr(8'h24, 32'(m_b));
        chk("R9 mode code", {30'd0, pin_alt_b[p], pin_alt_a[p]}, 32'(c));
        chk("R9 other pins gpio", 32'(pin_alt_a | pin_alt_b) & ~(32'd1 << p), 32'd0);
      end
    end
    check_all("R9 after modes");

    // R7: input synchronizer latency
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pin_in = NP'(v * 151 + 1);
      rd(8'h00, r); chk("R7 level before edge", r, 32'(m_lvl));
      @(negedge clk);
      rd(8'h00, r); chk("R7 level after one edge", r, 32'(m_lvl));
      @(negedge clk);
      m_lvl = NP'(v * 151 + 1);
      rd(8'h00, r); chk("R7 level after two edges", r, 32'(m_lvl));
      chk("R7 pins do not touch latch", 32'(pin_out), 32'(m_out));
    end

    // R10: unmapped and misaligned writes change nothing, read zero
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h11, 32'h0000_0000);
    check_all("R10 after stray writes");
    rd(8'h1C, r); chk("R10 rd 1C", r, 32'd0);
    rd(8'h28, r); chk("R10 rd 28", r, 32'd0);
    rd(8'h05, r); chk("R10 rd misaligned 05", r, 32'd0);
    rd(8'h21, r); chk("R10 rd misaligned 21", r, 32'd0);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_out = '0; m_dir = '0; m_pull = '0; m_a = '0; m_b = '0; m_lvl = '0;
    pin_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 second reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule